// File: doc/BRIEF.md
# Shift-and-Store Bus Register

This block is a serial-to-parallel converter with a second rank of storage between the shifter and a shared parallel bus. Bits arrive one per rising clock edge on a serial input and move through a chain of shift stages. A level-sensitive strobe opens a rank of storage latches, one behind each stage. While the strobe is high, the latches follow the shift stages. While it is low, they hold their contents, so the shifter can load the next word without disturbing the outputs.

An output enable puts the latched word onto the parallel outputs. The three-state behaviour is modelled as a data vector plus an active-high drive-enable per bit, so several instances can share one bus. Two serial cascade outputs carry the bit leaving the last stage, which lets devices be chained:

- The first cascade output changes on the rising edge.
- The second carries the same bit, updated at the following falling edge. This gives extra hold margin when the clock edges are slow.

Top module: `shift_store_reg`

## Requirements
- R1: While rst_ni is low, all shift stages, all storage latches and both cascade outputs are 0.
- R2: On each rising edge of clk_i, stage 0 takes ser_i and stage i takes the old stage i-1. After STAGES shifts with the word's most significant bit sent first, par_o bit i equals word bit i once the word is strobed and output is enabled.
- R3: While strobe_i is high, the storage latches are transparent and follow the shift stages, including across rising edges.
- R4: While oe_i is high, every bit of par_en_o is 1 and par_o equals the storage latches.
- R5: While oe_i is low, every bit of par_en_o is 0 (bus released) and par_o reads 0.
- R6: While strobe_i is low, the storage latches keep their value however many shifts take place.
- R7: cas_rise_o equals the last shift stage (stage STAGES-1) and changes only at a rising clock edge.
- R8: cas_fall_o carries the same bit as cas_rise_o, taken at the next falling edge. Between a rising edge and the following falling edge it still shows the bit from before that rising edge.
- R9: oe_i has no effect on cas_rise_o or cas_fall_o. Both keep shifting and stay driven while oe_i is low.
- R10: With the clock shared, feeding a second instance's ser_i from either cascade output forms a 2*STAGES-bit shift chain. Of 16 bits sent first-bit-first, the first 8 end up in the second instance and the last 8 end up in the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data in |
| strobe_i | input | 1 | Level-sensitive storage latch enable |
| oe_i | input | 1 | Parallel output enable |
| par_o | output | STAGES | Parallel data (0 when not driven) |
| par_en_o | output | STAGES | Per-bit drive-enable for the bus |
| cas_rise_o | output | 1 | Cascade bit, rising-edge timed |
| cas_fall_o | output | 1 | Cascade bit, falling-edge timed |

## Verification
The hardest situation to reach is the half-cycle window in which the two cascade outputs disagree. It exists only between a rising edge and the next falling edge, and only when the bit leaving the last stage has just changed. The stimulus drives data at falling edges and samples just after each edge of both kinds. The full sweep of all 256 words gives many such transitions, and the value expected before the falling edge is checked separately from the value expected after it. Chaining two followers, one per cascade output, and strobing all three devices after 16 shifts shows that the two timings deliver the same bit order.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned SSR_STAGES = 8;
  typedef enum logic {DRV_OFF = 1'b0, DRV_ON = 1'b1} drv_e;
endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  output logic [STAGES-1:0] stage_o
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_head
      assign d = ser_i;
    end else begin : g_body
      assign d = stage_o[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_o[i] <= 1'b0;
      else         stage_o[i] <= d;
    end
  end
endmodule

// File: rtl/ssr_store_latch.sv
module ssr_store_latch #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [STAGES-1:0] d_i,
  output logic [STAGES-1:0] q_o
);
  // transparent while strobe is high, holds otherwise
  always_latch begin
    if (!rst_ni)       q_o <= '0;
    else if (strobe_i) q_o <= d_i;
  end
endmodule

// File: rtl/ssr_bus_drive.sv
module ssr_bus_drive #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input  logic              oe_i,
  input  logic [STAGES-1:0] store_i,
  output logic [STAGES-1:0] par_o,
  output logic [STAGES-1:0] par_en_o
);
  import ssr_pkg::*;
  drv_e drv;
  assign drv = oe_i ? DRV_ON : DRV_OFF;

  for (genvar i = 0; i < STAGES; i++) begin : g_bit
    assign par_en_o[i] = (drv == DRV_ON);
    assign par_o[i]    = (drv == DRV_ON) ? store_i[i] : 1'b0;
  end
endmodule

// File: rtl/ssr_cascade.sv
module ssr_cascade (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tail_i,
  output logic fall_o
);
  // retimed to falling edge for slow-edge chaining
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_o <= 1'b0;
    else         fall_o <= tail_i;
  end
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              strobe_i,
  input  logic              oe_i,
  output logic [STAGES-1:0] par_o,
  output logic [STAGES-1:0] par_en_o,
  output logic              cas_rise_o,
  output logic              cas_fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] store_q;

  ssr_shift_chain #(.STAGES(STAGES)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .stage_o(shift_q)
  );

  ssr_store_latch #(.STAGES(STAGES)) u_store (
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .d_i     (shift_q),
    .q_o     (store_q)
  );

  ssr_bus_drive #(.STAGES(STAGES)) u_drive (
    .oe_i    (oe_i),
    .store_i (store_q),
    .par_o   (par_o),
    .par_en_o(par_en_o)
  );

  assign cas_rise_o = shift_q[LAST];

  ssr_cascade u_cas (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tail_i(shift_q[LAST]),
    .fall_o(cas_fall_o)
  );

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r3_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> store_q == shift_q);

  a_r4_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> (par_o == store_q) && (&par_en_o));

  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (par_en_o == '0) && (par_o == '0));

  a_r7_rise_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> cas_rise_o == $past(shift_q[LAST-1]));

  a_r8_fall_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> cas_fall_o == cas_rise_o);
endmodule

// File: tb/tb_shift_store_reg.sv
module tb_shift_store_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, ser, strb, oe;
  logic [W-1:0] par, en, par_r, en_r, par_f, en_f;
  logic cas_r, cas_f, rr_r, rr_f, fr_r, fr_f;

  int checks = 0;
  int fails = 0;
  logic [15:0] hist = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_store_reg #(.STAGES(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .strobe_i(strb), .oe_i(oe),
    .par_o(par), .par_en_o(en), .cas_rise_o(cas_r), .cas_fall_o(cas_f));

  shift_store_reg #(.STAGES(W)) dut_r (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(cas_r), .strobe_i(strb), .oe_i(oe),
    .par_o(par_r), .par_en_o(en_r), .cas_rise_o(rr_r), .cas_fall_o(rr_f));

  shift_store_reg #(.STAGES(W)) dut_f (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(cas_f), .strobe_i(strb), .oe_i(oe),
    .par_o(par_f), .par_en_o(en_f), .cas_rise_o(fr_r), .cas_fall_o(fr_f));

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // starts just after a falling edge, ends just after the next one
  task automatic shift_bit(input logic b, input string rtag);
    logic old;
    ser = b;
    old = hist[W-1];
    @(posedge clk);
    hist = {hist[14:0], b};
    #1;
    chk(cas_r == hist[W-1], rtag, {15'd0, cas_r}, {15'd0, hist[W-1]});
    chk(cas_f == old, "R8 before fall", {15'd0, cas_f}, {15'd0, old});
    @(negedge clk);
    #1;
    chk(cas_f == hist[W-1], "R8 after fall", {15'd0, cas_f}, {15'd0, hist[W-1]});
  endtask

  task automatic pulse_strobe();
    strb = 1'b1;
    #2;
    strb = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser = 1'b0; strb = 1'b0; oe = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(cas_r == 1'b0 && cas_f == 1'b0, "R1 cascade", {14'd0, cas_r, cas_f}, 16'd0);
    chk(en == '0, "R1 released", {8'd0, en}, 16'd0);
    oe = 1'b1; strb = 1'b1;
    #1;
    chk(par == '0 && en == '1, "R1 store zero", {8'd0, par}, 16'd0);
    strb = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R2 R4: full sweep of words, strobed then read
    for (int v = 0; v < 256; v++) begin
      for (int i = W - 1; i >= 0; i--) shift_bit(v[i], "R7 sweep");
      pulse_strobe();
      chk(par == v[W-1:0], "R2 word", {8'd0, par}, v[15:0]);
      chk(en == '1, "R4 enable", {8'd0, en}, 16'h00ff);
    end

    // R6: strobe low, shifting leaves stored word alone
    for (int i = W - 1; i >= 0; i--) shift_bit(~hist[i], "R7 hold");
    chk(par == 8'hff, "R6 hold", {8'd0, par}, 16'h00ff);
    pulse_strobe();
    chk(par == hist[W-1:0], "R6 restrobe", {8'd0, par}, {8'd0, hist[W-1:0]});

    // R3: transparent while strobe held high
    strb = 1'b1;
    for (int i = 0; i < 12; i++) begin
      shift_bit(1'((i * 5 + 1) % 3 == 0), "R7 transp");
      chk(par == hist[W-1:0], "R3 follow", {8'd0, par}, {8'd0, hist[W-1:0]});
    end
    strb = 1'b0;
    #1;

    // R5 R9: bus released, cascade still running
    oe = 1'b0;
    #1;
    chk(en == '0, "R5 released", {8'd0, en}, 16'd0);
    chk(par == '0, "R5 data", {8'd0, par}, 16'd0);
    for (int i = 0; i < 16; i++) shift_bit(1'(i % 3 == 1), "R9 oe low");
    chk(en == '0 && par == '0, "R5 after shift", {en, par}, 16'd0);
    oe = 1'b1;
    #1;

    // R10: two followers, one per cascade output
    for (int k = 0; k < 20; k++) begin
      logic [15:0] pat;
      pat = 16'(k * 16'h3a57 ^ 16'hc31e);
      for (int i = 15; i >= 0; i--) shift_bit(pat[i], "R7 chain");
      pulse_strobe();
      chk(par == pat[7:0], "R10 first dev", {8'd0, par}, {8'd0, pat[7:0]});
      chk(par_r == pat[15:8], "R10 rise chain", {8'd0, par_r}, {8'd0, pat[15:8]});
      chk(par_f == pat[15:8], "R10 fall chain", {8'd0, par_f}, {8'd0, pat[15:8]});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule